// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 32-bit instruction stream goes next. Each cycle it is given the address of the current instruction, the instruction word itself, and the values of the two source registers that the instruction names. From these it produces the address of the next instruction to fetch, a flag saying whether control flow left the sequential path, and a request to write a return address into the link register.

It handles conditional branches that test equality, inequality and the four unsigned orderings. It also handles a PC-relative jump with a long displacement, a jump to an address held in a register, and a jump that also records its return address. All displacements count in words and are measured from the address of the following instruction. Any other opcode falls through to that following address. The unit is purely combinational, so a fetch stage or a pipeline can wrap it with whatever registers its timing needs. The instruction memory, the register file and hazard handling sit outside it.

Top module: `branch_next_pc`

## Requirements
- R1: The opcode is instruction bits 31:26. Opcode 0x20 is taken when `opa_i == opb_i`, and opcode 0x21 is taken when they differ.
- R2: Opcode 0x23 is taken when `opa_i <= opb_i`, and opcode 0x25 is taken when `opa_i < opb_i`. Both operands are compared as unsigned numbers.
- R3: Opcode 0x27 is taken when `opa_i >= opb_i`, and opcode 0x29 is taken when `opa_i > opb_i`. Both operands are compared as unsigned numbers.
- R4: When a conditional branch is taken, `next_pc_o` is `pc_i + 4` plus the sign-extension of instruction bits 15:0, shifted left by two. `taken_o` is 1.
- R5: When a conditional branch is not taken, `next_pc_o` is `pc_i + 4` and `taken_o` is 0.
- R6: Opcode 0x2A gives `next_pc_o` equal to `pc_i + 4` plus the sign-extension of instruction bits 25:0, shifted left by two. `taken_o` is 1 and there is no link write.
- R7: Opcode 0x2B gives `next_pc_o = opa_i`, which is the value of the register named in bits 25:21. `taken_o` is 1 and there is no link write.
- R8: Opcode 0x2C jumps exactly as opcode 0x2A does. It also raises `link_we_o`, with `link_idx_o = 31` and `link_addr_o = pc_i + 4`.
- R9: Every other opcode, including the unused values 0x22, 0x24 and 0x2D and the value 0x00, gives `next_pc_o = pc_i + 4`, `taken_o = 0` and `link_we_o = 0`.
- R10: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| opa_i | input | 32 | Value of the first source register (bits 25:21) |
| opb_i | input | 32 | Value of the second source register (bits 20:16) |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Request to write the return address |
| link_idx_o | output | 5 | Register that receives the return address |
| link_addr_o | output | 32 | Return address (`pc_i + 4`) |

## Verification
Every result of this unit is due in the same cycle as its inputs, with no register in between. The bench therefore applies each instruction, waits a fixed settling delay away from any clock edge, and only then compares the next address, the taken flag and the link outputs. Each directed task sets up its own operands, so no check depends on an earlier scenario. Some cases probe the boundaries between signed and unsigned comparison, negative displacements, and address wrap at the top of the space.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter int XLEN     = 32,
  parameter int OPC_W    = 6,
  parameter int RIDX_W   = 5,
  parameter int BR_OFF_W = 16,
  parameter int J_OFF_W  = 26,
  parameter int LINK_REG = 31
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_addr_o
);

  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int BR_PAD  = XLEN - BR_OFF_W - 2;
  localparam int J_PAD   = XLEN - J_OFF_W - 2;

  localparam logic [OPC_W-1:0] OPC_EQ   = OPC_W'(8'h20);
  localparam logic [OPC_W-1:0] OPC_NE   = OPC_W'(8'h21);
  localparam logic [OPC_W-1:0] OPC_LEU  = OPC_W'(8'h23);
  localparam logic [OPC_W-1:0] OPC_LTU  = OPC_W'(8'h25);
  localparam logic [OPC_W-1:0] OPC_GEU  = OPC_W'(8'h27);
  localparam logic [OPC_W-1:0] OPC_GTU  = OPC_W'(8'h29);
  localparam logic [OPC_W-1:0] OPC_JREL = OPC_W'(8'h2A);
  localparam logic [OPC_W-1:0] OPC_JREG = OPC_W'(8'h2B);
  localparam logic [OPC_W-1:0] OPC_JLNK = OPC_W'(8'h2C);

  wire [OPC_W-1:0] opc     = instr_i[XLEN-1:OPC_LSB];
  wire [XLEN-1:0]  seq_pc  = pc_i + XLEN'(4);
  wire [XLEN-1:0]  br_disp = {{BR_PAD{instr_i[BR_OFF_W-1]}}, instr_i[BR_OFF_W-1:0], 2'b00};
  wire [XLEN-1:0]  j_disp  = {{J_PAD{instr_i[J_OFF_W-1]}}, instr_i[J_OFF_W-1:0], 2'b00};
  wire             a_eq_b  = (opa_i == opb_i);
  wire             a_lt_b  = (opa_i < opb_i);

  assign link_idx_o  = RIDX_W'(LINK_REG);
  assign link_addr_o = seq_pc;

  logic            is_cond;
  logic            cond_ok;
  logic [XLEN-1:0] nxt;
  logic            tk;
  logic            lwe;

  always_comb begin
    is_cond = 1'b0;
    cond_ok = 1'b0;
    tk      = 1'b0;
    lwe     = 1'b0;
    nxt     = seq_pc;
    case (opc)
      OPC_EQ:  begin is_cond = 1'b1; cond_ok = a_eq_b;            end
      OPC_NE:  begin is_cond = 1'b1; cond_ok = !a_eq_b;           end
      OPC_LEU: begin is_cond = 1'b1; cond_ok = a_lt_b || a_eq_b;  end
      OPC_LTU: begin is_cond = 1'b1; cond_ok = a_lt_b;            end
      OPC_GEU: begin is_cond = 1'b1; cond_ok = !a_lt_b;           end
      OPC_GTU: begin is_cond = 1'b1; cond_ok = !a_lt_b && !a_eq_b; end
      OPC_JREL: begin tk = 1'b1; nxt = seq_pc + j_disp; end
      OPC_JREG: begin tk = 1'b1; nxt = opa_i;           end
      OPC_JLNK: begin tk = 1'b1; lwe = 1'b1; nxt = seq_pc + j_disp; end
      default: ;
    endcase
    if (is_cond && cond_ok) begin
      tk  = 1'b1;
      nxt = seq_pc + br_disp;
    end
    next_pc_o = nxt;
    taken_o   = tk;
    link_we_o = lwe;

    // R5
    seq_when_not_taken_chk: assert (tk || nxt == pc_i + XLEN'(4));
    // R8
    link_only_jlnk_chk: assert (!lwe || (opc == OPC_JLNK && tk));
    // R7
    jreg_target_chk: assert (opc != OPC_JREG || (tk && nxt == opa_i));
    // R1
    eq_branch_chk: assert (opc != OPC_EQ || tk == (opa_i == opb_i));
    // R3
    geu_ltu_pair_chk: assert (opc != OPC_GEU || tk == !(opa_i < opb_i));
    // R9
    other_opc_chk: assert (is_cond || tk || !lwe);
  end

endmodule

// File: tb/branch_next_pc_tb.sv
module branch_next_pc_tb;
  logic        clk = 1'b0;
  logic [31:0] pc, instr, opa, opb;
  logic [31:0] next_pc, link_addr;
  logic        taken, link_we;
  logic [4:0]  link_idx;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  branch_next_pc u_dut (
    .pc_i(pc), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_idx_o(link_idx), .link_addr_o(link_addr)
  );

  function automatic logic [31:0] mk_b(input logic [5:0] op, input logic [15:0] off);
    return {op, 5'd1, 5'd2, off};
  endfunction

  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction

  task automatic apply(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    pc = p; instr = i; opa = a; opb = b;
    #2;
  endtask

  task automatic expect_out(input string req, input logic [31:0] e_pc,
                            input logic e_tk, input logic e_lwe);
    checks++;
    if (next_pc !== e_pc || taken !== e_tk || link_we !== e_lwe) begin
      fails++;
      $display("FAIL %s: next=%h taken=%b lwe=%b expected next=%h taken=%b lwe=%b",
               req, next_pc, taken, link_we, e_pc, e_tk, e_lwe);
    end
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0, 32'h0, 32'h0);
    expect_out("R9 idle", 32'h4, 1'b0, 1'b0);
  endtask

  task automatic t_eq_ne;
    apply(32'h1000, mk_b(6'h20, 16'h0010), 32'h7, 32'h7);
    expect_out("R1 eq taken", 32'h1044, 1'b1, 1'b0);
    apply(32'h1000, mk_b(6'h20, 16'h0010), 32'h7, 32'h8);
    expect_out("R1 eq not taken", 32'h1004, 1'b0, 1'b0);
    apply(32'h1000, mk_b(6'h21, 16'hFFFE), 32'h7, 32'h8);
    expect_out("R1 R4 ne taken back", 32'h0FFC, 1'b1, 1'b0);
    apply(32'h1000, mk_b(6'h21, 16'hFFFE), 32'h9, 32'h9);
    expect_out("R5 ne not taken", 32'h1004, 1'b0, 1'b0);
  endtask

  task automatic t_leu_ltu;
    apply(32'h2000, mk_b(6'h23, 16'h0001), 32'h5, 32'h5);
    expect_out("R2 leu equal", 32'h2008, 1'b1, 1'b0);
    apply(32'h2000, mk_b(6'h23, 16'h0001), 32'hFFFF_FFFF, 32'h1);
    expect_out("R2 leu unsigned big", 32'h2004, 1'b0, 1'b0);
    apply(32'h2000, mk_b(6'h25, 16'h0100), 32'h1, 32'hFFFF_FFFF);
    expect_out("R2 ltu taken", 32'h2404, 1'b1, 1'b0);
    apply(32'h2000, mk_b(6'h25, 16'h0100), 32'h3, 32'h3);
    expect_out("R2 ltu equal", 32'h2004, 1'b0, 1'b0);
  endtask

  task automatic t_geu_gtu;
    apply(32'h3000, mk_b(6'h27, 16'h8000), 32'h8000_0000, 32'h1);
    expect_out("R3 R4 geu min offset", 32'h3004 - 32'h0002_0000, 1'b1, 1'b0);
    apply(32'h3000, mk_b(6'h27, 16'h0004), 32'h0, 32'h1);
    expect_out("R3 geu not taken", 32'h3004, 1'b0, 1'b0);
    apply(32'h3000, mk_b(6'h29, 16'h0004), 32'h6, 32'h6);
    expect_out("R3 gtu equal", 32'h3004, 1'b0, 1'b0);
    apply(32'h3000, mk_b(6'h29, 16'h0004), 32'h2, 32'h1);
    expect_out("R3 gtu taken", 32'h3014, 1'b1, 1'b0);
  endtask

  task automatic t_jumps;
    apply(32'h4000, mk_j(6'h2A, 26'h000_0100), 32'h0, 32'h0);
    expect_out("R6 jrel fwd", 32'h4404, 1'b1, 1'b0);
    apply(32'h4000, mk_j(6'h2A, 26'h3FF_FFFF), 32'h0, 32'h0);
    expect_out("R6 jrel self", 32'h4000, 1'b1, 1'b0);
    apply(32'h4000, {6'h2B, 5'd7, 21'd0}, 32'hDEAD_BEE0, 32'h0);
    expect_out("R7 jreg", 32'hDEAD_BEE0, 1'b1, 1'b0);
    apply(32'h5000, mk_j(6'h2C, 26'h200_0000), 32'h0, 32'h0);
    expect_out("R8 jlnk", 32'h5004 - 32'h0800_0000, 1'b1, 1'b1);
    checks++;
    if (link_idx !== 5'd31 || link_addr !== 32'h5004) begin
      fails++;
      $display("FAIL R8 link: idx=%0d addr=%h expected idx=31 addr=%h", link_idx, link_addr, 32'h5004);
    end
  endtask

  task automatic t_other;
    apply(32'h6000, mk_b(6'h22, 16'h0010), 32'h1, 32'h1);
    expect_out("R9 op22", 32'h6004, 1'b0, 1'b0);
    apply(32'h6000, mk_b(6'h24, 16'h0010), 32'h0, 32'h1);
    expect_out("R9 op24", 32'h6004, 1'b0, 1'b0);
    apply(32'h6000, mk_j(6'h2D, 26'h000_0010), 32'h1, 32'h1);
    expect_out("R9 op2D", 32'h6004, 1'b0, 1'b0);
  endtask

  task automatic t_wrap;
    apply(32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0);
    expect_out("R10 seq wrap", 32'h0, 1'b0, 1'b0);
    apply(32'hFFFF_FFF0, mk_b(6'h20, 16'h0010), 32'h4, 32'h4);
    expect_out("R10 branch wrap", 32'h34, 1'b1, 1'b0);
    apply(32'h0, mk_j(6'h2A, 26'h3FF_FFFC), 32'h0, 32'h0);
    expect_out("R10 jump under", 32'hFFFF_FFF4, 1'b1, 1'b0);
  endtask

  initial begin
    pc = '0; instr = '0; opa = '0; opb = '0;
    t_idle();
    t_eq_ne();
    t_leu_ltu();
    t_geu_gtu();
    t_jumps();
    t_other();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected under 5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule